// File: doc/BRIEF.md
# Dual-Flash Command Snoop and Bit Striper

This block sits between a byte transmit stream and two parallel serial flash buses that run in lockstep. At the start of every chip-select frame it treats the first transmitted byte as a flash instruction code. From that code it works out how many address and dummy bytes follow. All of those header bytes are copied unchanged onto every active bus. Once the header has been counted off, the block switches to striping. In striping, each group of bytes is bit-interleaved across the buses on transmit, and the bytes returned by the buses are de-interleaved back into the original order on receive. Unknown instruction codes are never striped.

The transmit side takes one byte per handshake. The block gathers a full stripe group, then issues one transfer that carries one byte per bus. Only one transfer is in flight at a time. When the buses return their bytes, the reassembled bytes go into a banked receive queue that a consumer pops one byte at a time. The serial shifting is done outside this block. A frame boundary is signalled by holding `frame_idle` high, which means every chip select is released.

Top module: `dual_flash_striper`

## Requirements
- R1: After reset no transfer is issued (`bus_tx_valid` low), the receive queue is empty (`rx_valid` low), `rx_overflow` is low and `tx_ready` is high once `frame_idle` is low.
- R2: While `frame_idle` is high, `tx_ready` is low, any partly gathered stripe group is discarded, and the classifier returns to its checking state. The first byte accepted after `frame_idle` falls is taken as the instruction code.
- R3: Instruction codes 0x02, 0x03, 0x32 and 0xA2 are followed by exactly 3 header bytes sent unstriped. The byte after them starts striping.
- R4: Instruction codes 0x0B, 0x3B, 0x6B and 0xBB are followed by exactly 4 unstriped header bytes before striping starts.
- R5: Instruction code 0xEB is followed by exactly 6 unstriped header bytes before striping starts.
- R6: Any other instruction code keeps every later byte of the frame unstriped.
- R7: When not striping, each accepted byte becomes one transfer, and that transfer appears on `bus_tx` one cycle after the accepting edge. The byte is copied onto every active lane. Only the lane 0 reply byte (`bus_rx[7:0]`) is pushed into the receive queue.
- R8: When striping with two lanes, two accepted bytes form one transfer. Call the first byte D0 and the second D1; the input is {D1,D0} with D0 in bits 7:0. Output lane k, bit j is input bit k+2*j, so lane 0 carries the even bits and lane 1 the odd bits. Lane k occupies bus bits 8k+7:8k. The reply is mapped back by the inverse rule, and the two bytes are pushed into the queue first byte first.
- R9: If the receive queue lacks room for the whole group a reply carries, the whole group is dropped. `rx_overflow` then pulses high for one cycle, starting one cycle after the reply edge. The queued bytes are unchanged.
- R10: Two lanes are active (`bus_lane_act` = 2'b11) only when `cfg_dual_mem` and `cfg_split_bus` are both high. Otherwise only lane 0 is active (`bus_lane_act` = 2'b01), lane 1 is driven to zero, and a striped byte is sent alone and unchanged.
- R11: Only one transfer is in flight: `tx_ready` stays low from an issuing edge until the reply edge. Queued bytes come out of `rx_byte` in arrival order, one per cycle in which `rx_pop` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual_mem | input | 1 | Two memories fitted |
| cfg_split_bus | input | 1 | Memories on separate buses |
| frame_idle | input | 1 | All chip selects released (frame boundary) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_byte | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| bus_tx | output | 16 | Per-lane outgoing bytes, lane k in bits 8k+7:8k |
| bus_lane_act | output | 2 | Lanes taking part in the current transfer |
| bus_tx_valid | output | 1 | One-cycle transfer issue strobe |
| bus_rx | input | 16 | Per-lane returned bytes |
| bus_rx_valid | input | 1 | Reply strobe for the transfer in flight |
| rx_valid | output | 1 | Receive queue not empty |
| rx_byte | output | 8 | Head of the receive queue |
| rx_pop | input | 1 | Remove head byte |
| rx_overflow | output | 1 | One-cycle pulse when a reply group is dropped |

## Verification
A transfer is due on `bus_tx` in the cycle right after the edge that accepts its last byte. A reply pushed at one edge is readable on `rx_byte`, or reported on `rx_overflow`, in the cycle after that edge. The bench drives its inputs and samples the outputs on falling clock edges only. This way every comparison lands in the first cycle where the value is due. The bench's bus model checks each strobe against the next transfer it expects, then answers after a random gap of zero to three cycles. The bench predicts queue occupancy itself, so it knows in advance which reply must overflow.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  localparam int BYTE_W = 8;
  localparam int SKIP_W = 3;

  typedef enum logic [1:0] {
    SN_CHECK  = 2'd0,
    SN_COUNT  = 2'd1,
    SN_PLAIN  = 2'd2,
    SN_STRIPE = 2'd3
  } snoop_e;

  // Header bytes that follow an instruction code; zero means "never stripe".
  function automatic logic [SKIP_W-1:0] cmd_skip(input logic [BYTE_W-1:0] code);
    logic [SKIP_W-1:0] r;
    case (code)
      8'h02, 8'h03, 8'h32, 8'hA2: r = 3'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: r = 3'd4;
      8'hEB:                      r = 3'd6;
      default:                    r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dfs_snoop.sv
module dfs_snoop
  import dfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_idle,
  input  logic              step,
  input  logic [BYTE_W-1:0] code,
  output logic              striping
);

  snoop_e            state_q;
  logic [SKIP_W-1:0] left_q;
  logic [SKIP_W-1:0] skip;

  assign skip = cmd_skip(code);

  always_ff @(posedge clk) begin
    if (rst || frame_idle) begin
      state_q <= SN_CHECK;
      left_q  <= '0;
    end else if (step) begin
      case (state_q)
        SN_CHECK: begin
          if (skip == '0) begin
            state_q <= SN_PLAIN;
          end else begin
            state_q <= SN_COUNT;
            left_q  <= skip;
          end
        end
        SN_COUNT: begin
          left_q <= left_q - 1'b1;
          if (left_q == SKIP_W'(1)) state_q <= SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  assign striping = (state_q == SN_STRIPE);

endmodule

// File: rtl/dfs_bitweave.sv
module dfs_bitweave #(
  parameter int LANES   = 2,
  parameter int BW      = 8,
  parameter bit UNWEAVE = 1'b0
) (
  input  logic [LANES*BW-1:0] din,
  output logic [LANES*BW-1:0] dout
);

  // Lane k bit j pairs with linear bit k + LANES*j of the flat byte vector.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < BW; j++) begin : g_bit
      localparam int LIN = k + LANES * j;
      if (UNWEAVE) begin : g_inv
        assign dout[LIN] = din[k*BW + j];
      end else begin : g_fwd
        assign dout[k*BW + j] = din[LIN];
      end
    end
  end

endmodule

// File: rtl/dfs_rxq.sv
module dfs_rxq #(
  parameter int LANES = 2,
  parameter int BW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic [$clog2(LANES):0] push_n,
  input  logic [LANES*BW-1:0]   push_data,
  input  logic                  pop,
  output logic                  valid,
  output logic [BW-1:0]         dout,
  output logic                  ovf
);

  localparam int LB   = $clog2(LANES);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int ROWS = DEPTH / LANES;

  logic [CW-1:0] wr_q, rd_q;
  logic [CW-1:0] level, room;
  logic          accept;
  logic [BW-1:0] bank_q [LANES];

  assign level  = wr_q - rd_q;
  assign room   = CW'(DEPTH) - level;
  assign accept = push && (room >= CW'(push_n));
  assign valid  = (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= push && !accept;
      if (accept) wr_q <= wr_q + CW'(push_n);
      if (pop && valid) rd_q <= rd_q + 1'b1;
    end
  end

  // One single-port-write bank per lane: consecutive bytes land in distinct banks.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BW-1:0] mem [ROWS];
    logic [LB-1:0] kb;
    logic [PW-1:0] wa;
    logic          we;

    assign kb = LB'(b) - wr_q[LB-1:0];
    assign wa = wr_q[PW-1:0] + PW'(kb);
    assign we = accept && ({1'b0, kb} < push_n);

    always_ff @(posedge clk) begin
      if (we) mem[wa[PW-1:LB]] <= push_data[kb*BW +: BW];
    end

    assign bank_q[b] = mem[rd_q[PW-1:LB]];
  end

  assign dout = bank_q[rd_q[LB-1:0]];

endmodule

// File: rtl/dual_flash_striper.sv
module dual_flash_striper
  import dfs_pkg::*;
#(
  parameter int NBUS      = 2,
  parameter int RXQ_DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_dual_mem,
  input  logic                   cfg_split_bus,
  input  logic                   frame_idle,
  input  logic                   tx_valid,
  input  logic [7:0]             tx_byte,
  output logic                   tx_ready,
  output logic [NBUS*8-1:0]      bus_tx,
  output logic [NBUS-1:0]        bus_lane_act,
  output logic                   bus_tx_valid,
  input  logic [NBUS*8-1:0]      bus_rx,
  input  logic                   bus_rx_valid,
  output logic                   rx_valid,
  output logic [7:0]             rx_byte,
  input  logic                   rx_pop,
  output logic                   rx_overflow
);

  localparam int LB  = $clog2(NBUS);
  localparam int GW  = NBUS * BYTE_W;

  logic                striping, wide, busy_q, pend_wide_q;
  logic                accept, issue, group_done;
  logic [LB:0]         hold_cnt_q;
  logic [BYTE_W-1:0]   hold_q [NBUS-1];
  logic [GW-1:0]       grp, woven, unwoven, lanes_nx, push_data;
  logic [NBUS-1:0]     act_nx;
  logic                push;
  logic [LB:0]         push_n;

  assign wide       = cfg_dual_mem && cfg_split_bus;
  assign tx_ready   = !busy_q && !frame_idle;
  assign accept     = tx_valid && tx_ready;
  assign group_done = !striping || !wide || (hold_cnt_q == (LB+1)'(NBUS-1));
  assign issue      = accept && group_done;

  dfs_snoop u_snoop (
    .clk        (clk),
    .rst        (rst),
    .frame_idle (frame_idle),
    .step       (issue),
    .code       (tx_byte),
    .striping   (striping)
  );

  // Stripe group: held bytes first, the byte being accepted last.
  for (genvar k = 0; k < NBUS; k++) begin : g_grp
    if (k == NBUS - 1) begin : g_last
      assign grp[k*BYTE_W +: BYTE_W] = tx_byte;
    end else begin : g_held
      assign grp[k*BYTE_W +: BYTE_W] = hold_q[k];
    end
  end

  dfs_bitweave #(.LANES(NBUS), .BW(BYTE_W), .UNWEAVE(1'b0)) u_weave (
    .din  (grp),
    .dout (woven)
  );

  dfs_bitweave #(.LANES(NBUS), .BW(BYTE_W), .UNWEAVE(1'b1)) u_unweave (
    .din  (bus_rx),
    .dout (unwoven)
  );

  always_comb begin
    lanes_nx = '0;
    act_nx   = '0;
    if (wide && striping) begin
      lanes_nx = woven;
      act_nx   = '1;
    end else if (wide) begin
      lanes_nx = {NBUS{tx_byte}};
      act_nx   = '1;
    end else begin
      lanes_nx[BYTE_W-1:0] = tx_byte;
      act_nx[0]            = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      pend_wide_q  <= 1'b0;
      hold_cnt_q   <= '0;
      bus_tx_valid <= 1'b0;
      bus_tx       <= '0;
      bus_lane_act <= '0;
    end else begin
      bus_tx_valid <= issue;
      if (frame_idle) hold_cnt_q <= '0;
      if (issue) begin
        bus_tx       <= lanes_nx;
        bus_lane_act <= act_nx;
        busy_q       <= 1'b1;
        pend_wide_q  <= wide && striping;
        hold_cnt_q   <= '0;
      end else if (accept) begin
        hold_cnt_q <= hold_cnt_q + 1'b1;
      end
      if (busy_q && bus_rx_valid) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !issue) hold_q[hold_cnt_q[LB-1:0]] <= tx_byte;
  end

  assign push   = busy_q && bus_rx_valid;
  assign push_n = pend_wide_q ? (LB+1)'(NBUS) : (LB+1)'(1);

  always_comb begin
    push_data = '0;
    if (pend_wide_q) push_data = unwoven;
    else             push_data[BYTE_W-1:0] = bus_rx[BYTE_W-1:0];
  end

  dfs_rxq #(.LANES(NBUS), .BW(BYTE_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_n    (push_n),
    .push_data (push_data),
    .pop       (rx_pop),
    .valid     (rx_valid),
    .dout      (rx_byte),
    .ovf       (rx_overflow)
  );

endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int NBUS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_dual_mem,
  input logic            cfg_split_bus,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [NBUS-1:0] bus_lane_act,
  input logic            bus_tx_valid,
  input logic            bus_rx_valid,
  input logic            rx_overflow
);

  // R11: the issuing edge leaves the transmit side stalled.
  a_r11_stall_after_issue: assert property (@(posedge clk) disable iff (rst)
    bus_tx_valid |-> !tx_ready);

  // R7: a transfer strobe follows an offered byte.
  a_r7_issue_from_byte: assert property (@(posedge clk) disable iff (rst)
    bus_tx_valid |-> $past(tx_valid));

  // R10: lane usage follows the configuration of the issuing cycle.
  a_r10_single_lane: assert property (@(posedge clk) disable iff (rst)
    (bus_tx_valid && !$past(cfg_dual_mem && cfg_split_bus)) |-> (bus_lane_act == NBUS'(1)));

  a_r10_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (bus_tx_valid && $past(cfg_dual_mem && cfg_split_bus)) |-> (&bus_lane_act));

  // R9: an overflow pulse stems from a reply and lasts one cycle.
  a_r9_ovf_from_reply: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |-> $past(bus_rx_valid));

  a_r9_ovf_single: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |=> !rx_overflow);

endmodule

bind dual_flash_striper dfs_checker #(.NBUS(NBUS)) u_chk (.*);

// File: tb/dual_flash_striper_test.sv
module dual_flash_striper_test;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dual_mem = 1'b1, cfg_split_bus = 1'b1;
  logic        frame_idle = 1'b1;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic        tx_ready;
  logic [15:0] bus_tx;
  logic [1:0]  bus_lane_act;
  logic        bus_tx_valid;
  logic [15:0] bus_rx = '0;
  logic        bus_rx_valid = 1'b0;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_pop = 1'b0;
  logic        rx_overflow;

  always #5 clk = ~clk;

  dual_flash_striper #(.NBUS(2), .RXQ_DEPTH(DEPTH)) uut (.*);

  int nvec = 0, nbad = 0;
  logic [15:0] exp_tx[$];
  logic [1:0]  exp_act[$];
  bit          exp_wide[$];
  string       exp_tag[$];
  logic [7:0]  exp_rx[$];
  int          level = 0;
  bit          resp_busy = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] weave2(input logic [15:0] d);
    logic [15:0] o;
    for (int k = 0; k < 2; k++)
      for (int j = 0; j < 8; j++) o[k*8+j] = d[k + 2*j];
    return o;
  endfunction

  function automatic logic [15:0] unweave2(input logic [15:0] r);
    logic [15:0] o;
    for (int k = 0; k < 2; k++)
      for (int j = 0; j < 8; j++) o[k + 2*j] = r[k*8+j];
    return o;
  endfunction

  function automatic int hdr_len(input logic [7:0] c);
    if (c == 8'h02 || c == 8'h03 || c == 8'h32 || c == 8'hA2) return 3;
    if (c == 8'h0B || c == 8'h3B || c == 8'h6B || c == 8'hBB) return 4;
    if (c == 8'hEB) return 6;
    return 0;
  endfunction

  // Bus model: checks each transfer, replies after a random gap.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_tx_valid) begin
        logic [15:0] rep, got;
        bit wide;
        string tag;
        int n;
        resp_busy = 1;
        got = bus_tx;
        if (exp_tx.size() == 0) begin
          check(0, "R7 unexpected transfer", {16'h0, got}, 32'h0);
          wide = 0; tag = "R7";
        end else begin
          logic [15:0] e;
          logic [1:0] ea;
          e = exp_tx.pop_front(); ea = exp_act.pop_front();
          wide = exp_wide.pop_front(); tag = exp_tag.pop_front();
          check(got == e, tag, {16'h0, got}, {16'h0, e});
          check(bus_lane_act == ea, "R10 lanes", {30'h0, bus_lane_act}, {30'h0, ea});
        end
        rep = got ^ 16'($urandom);
        repeat ($urandom % 4) @(negedge clk);
        bus_rx = rep; bus_rx_valid = 1'b1;
        @(negedge clk);
        bus_rx_valid = 1'b0;
        n = wide ? 2 : 1;
        if (level + n > DEPTH) begin
          check(rx_overflow == 1'b1, "R9 overflow pulse", {31'h0, rx_overflow}, 32'h1);
        end else begin
          check(rx_overflow == 1'b0, "R9 no overflow", {31'h0, rx_overflow}, 32'h0);
          if (wide) begin
            logic [15:0] u;
            u = unweave2(rep);
            exp_rx.push_back(u[7:0]); exp_rx.push_back(u[15:8]);
          end else begin
            exp_rx.push_back(rep[7:0]);
          end
          level += n;
        end
        resp_busy = 0;
      end
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_byte = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (exp_tx.size() != 0 || resp_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input bit dm, input bit sb, input logic [7:0] bytes[$]);
    int st, left;
    logic [7:0] first;
    bit have;
    bit wide;
    string stag;
    @(negedge clk);
    frame_idle = 1'b1; cfg_dual_mem = dm; cfg_split_bus = sb;
    @(negedge clk);
    check(tx_ready == 1'b0, "R2 ready low at frame boundary", {31'h0, tx_ready}, 32'h0);
    frame_idle = 1'b0;
    wide = dm && sb;
    st = 0; left = 0; have = 0; stag = "R8";
    foreach (bytes[i]) begin
      logic [7:0] b;
      b = bytes[i];
      if (st == 3 && wide) begin
        if (!have) begin
          first = b; have = 1;
        end else begin
          exp_tx.push_back(weave2({b, first})); exp_act.push_back(2'b11);
          exp_wide.push_back(1); exp_tag.push_back(stag); stag = "R8";
          have = 0;
        end
      end else begin
        string t;
        if (!wide) t = "R10";
        else if (st == 0) t = "R2";
        else if (st == 2) t = "R6";
        else t = "R7";
        exp_tx.push_back(wide ? {b, b} : {8'h00, b});
        exp_act.push_back(wide ? 2'b11 : 2'b01);
        exp_wide.push_back(0); exp_tag.push_back(t);
      end
      if (st == 0) begin
        left = hdr_len(b);
        st = (left == 0) ? 2 : 1;
        stag = (left == 3) ? "R3" : (left == 4) ? "R4" : "R5";
      end else if (st == 1) begin
        left--;
        if (left == 0) st = 3;
      end
      put_byte(b);
    end
    wait_quiet();
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_rx.size() != 0) begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      check(rx_valid == 1'b1, "R11 data present", {31'h0, rx_valid}, 32'h1);
      check(rx_byte == e, "R11 order/R8 reassembly", {24'h0, rx_byte}, {24'h0, e});
      rx_pop = 1'b1;
      @(negedge clk);
    end
    rx_pop = 1'b0;
    check(rx_valid == 1'b0, "R11 queue empty after drain", {31'h0, rx_valid}, 32'h0);
    level = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [7:0] f[$];
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_tx_valid == 1'b0, "R1 no transfer", {31'h0, bus_tx_valid}, 32'h0);
    check(rx_valid == 1'b0, "R1 queue empty", {31'h0, rx_valid}, 32'h0);
    check(rx_overflow == 1'b0, "R1 overflow low", {31'h0, rx_overflow}, 32'h0);
    frame_idle = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready", {31'h0, tx_ready}, 32'h1);

    // R3: three header bytes then striping
    f = '{8'h03, 8'h12, 8'h34, 8'h56, 8'hA5, 8'h0F, 8'hFF, 8'h00};
    send_frame(1, 1, f); drain();
    // R4
    f = '{8'h6B, 8'h01, 8'h02, 8'h03, 8'h00, 8'hC3, 8'h3C, 8'h81, 8'h7E};
    send_frame(1, 1, f); drain();
    // R5
    f = '{8'hEB, 8'h10, 8'h20, 8'h30, 8'hA0, 8'h00, 8'h00, 8'h55, 8'hAA, 8'h96, 8'h69};
    send_frame(1, 1, f); drain();
    // R6: unknown code stays unstriped
    f = '{8'h9F, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    send_frame(1, 1, f); drain();
    // R10: one lane only when not both configuration bits set
    f = '{8'h0B, 8'h01, 8'h02, 8'h03, 8'h04, 8'hDE, 8'hAD};
    send_frame(1, 0, f); drain();
    f = '{8'hA2, 8'h01, 8'h02, 8'h03, 8'hBE, 8'hEF};
    send_frame(0, 1, f); drain();
    // R2: odd data byte left over, discarded at frame end
    f = '{8'h32, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hC3, 8'h77};
    send_frame(1, 1, f); drain();
    // R9: fill the queue without draining
    f = '{8'h02, 8'h00, 8'h01, 8'h02};
    for (int i = 0; i < 24; i++) f.push_back(8'(i * 37 + 5));
    send_frame(1, 1, f); drain();

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] codes[10];
      int len;
      codes = '{8'h03, 8'h02, 8'hA2, 8'h32, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h00};
      f = {};
      f.push_back(($urandom % 10 == 9) ? 8'($urandom) : codes[$urandom % 9]);
      len = 1 + $urandom % 12;
      for (int i = 0; i < len; i++) f.push_back(8'($urandom));
      send_frame(($urandom % 4) != 0, ($urandom % 4) != 0, f);
      if (($urandom % 3) != 0 || level > 8) drain();
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule